// File: doc/BRIEF.md
# 24-Hour BCD Time Counter

This block holds the time of day as six binary-coded decimal digits: units and tens of seconds, of minutes and of hours. A one-second tick enable, generated elsewhere from the system clock, advances the count by one second. The digits form a ripple-style chain: each digit steps when the digit below it wraps. The count rolls from 23:59:59 back to 00:00:00. On the clock edge where that happens, a single-cycle day-wrap pulse appears together with the all-zero time.

Each digit finds its own terminal value as part of its next-state logic. Units digits wrap after 9. Tens-of-seconds and tens-of-minutes wrap after 5. The hours-tens digit has two storage bits and wraps after 2. The hours-units digit wraps after 9 in the first twenty hours and after 3 once the hours tens reads 2. The digit codes 10 to 15 therefore never reach the outputs. All state changes on the system clock. The active-low master reset first passes through a synchroniser and then clears the digits synchronously.

Top module: `tod_bcd_counter`

## Requirements
- R1: `rst_n` low passes through a two-stage synchroniser. Low sampled at edge k clears all digits and `day_wrap` at edge k+2, and they stay cleared while the reset is active. A tick present during reset has no effect.
- R2: In a cycle with `sec_tick` low, no digit output changes on the next edge.
- R3: `sec_ones` steps 0 to 9 on ticks and returns to 0 on the tick after 9, carrying into `sec_tens`.
- R4: `sec_tens` and `min_tens` each hold 0 to 5 and return to 0 instead of reaching 6, carrying into the next digit.
- R5: The carry chain is in the fixed order `sec_ones`, `sec_tens`, `min_ones`, `min_tens`, `hr_ones`, `hr_tens`. `min_ones` steps only when both seconds digits wrap on the same tick.
- R6: While `hr_tens` is 0 or 1, `hr_ones` steps 0 to 9 and returns to 0.
- R7: While `hr_tens` is 2, `hr_ones` never exceeds 3. The tick after 23:59:59 gives 00:00:00.
- R8: `hr_tens` takes only the values 0, 1 and 2, and its bits 3:2 are always 0.
- R9: `day_wrap` is 1 for exactly the one cycle in which the outputs first show 00:00:00 after 23:59:59, and is 0 at all other times.
- R10: The first accepted tick after reset gives 00:00:01. No digit ever shows a value from 10 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset, asynchronous to `clk`; synchronised inside |
| sec_tick | input | 1 | One-cycle enable, once per second |
| sec_ones | output | 4 | Seconds units, BCD 0–9 |
| sec_tens | output | 4 | Seconds tens, BCD 0–5 |
| min_ones | output | 4 | Minutes units, BCD 0–9 |
| min_tens | output | 4 | Minutes tens, BCD 0–5 |
| hr_ones | output | 4 | Hours units, BCD 0–9 (0–3 when hours tens is 2) |
| hr_tens | output | 4 | Hours tens, 0–2, bits 3:2 always 0 |
| day_wrap | output | 1 | One-cycle pulse when the time rolls over to 00:00:00 |

## Verification
The bench runs a full day of back-to-back ticks, so every digit boundary is crossed. These include 09→10 and 19→20 in the hours, where a design that always applied the short limit to the hours units would jump early. They also include 23:59:59, where a design that forgot the conditional limit would show 24:00:00 or a hex digit. Irregular tick gaps, and stretches with no tick at all, expose a digit that steps on the clock rather than on the enable, or one that steps on a carry from the wrong neighbour. A reset pulled low in the middle of counting, with ticks still arriving, exposes a design that skips the synchroniser, lets a tick win over reset, or leaves a stale wrap pulse behind.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 6;

  typedef enum logic [1:0] {
    DK_UNITS,
    DK_TENS,
    DK_HR_UNITS,
    DK_HR_TENS
  } digit_kind_e;

  // Role of each position in the chain, lowest digit first.
  function automatic digit_kind_e kind_of(input int pos);
    case (pos)
      1, 3:    return DK_TENS;
      4:       return DK_HR_UNITS;
      5:       return DK_HR_TENS;
      default: return DK_UNITS;
    endcase
  endfunction

  // True when the incremented value 'raw' is past the digit's last legal code.
  function automatic logic digit_overflow(input digit_kind_e kind,
                                          input logic [DIGIT_W-1:0] raw,
                                          input logic tens_at_two);
    logic past_nine;
    past_nine = raw[3] & (raw[2] | raw[1]);
    case (kind)
      DK_UNITS:    return past_nine;
      DK_TENS:     return raw == 4'd6;
      DK_HR_UNITS: return tens_at_two ? (raw == 4'd4) : past_nine;
      default:     return raw[1] & raw[0];
    endcase
  endfunction

endpackage

// File: rtl/tod_reset_sync.sv
module tod_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_active
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[STAGES-2:0], rst_n_in};
  end

  assign rst_active = ~sync_q[STAGES-1];

endmodule

// File: rtl/tod_digit.sv
module tod_digit
  import tod_pkg::*;
#(
  parameter digit_kind_e KIND = DK_UNITS
) (
  input  logic               clk,
  input  logic               srst,
  input  logic               inc,
  input  logic               tens_at_two,
  output logic [DIGIT_W-1:0] value,
  output logic               carry
);

  localparam int STORE_W = (KIND == DK_HR_TENS) ? 2 : DIGIT_W;

  logic [STORE_W-1:0] cnt_q;
  logic [DIGIT_W-1:0] raw;
  logic               ovf;

  assign raw   = DIGIT_W'(cnt_q) + DIGIT_W'(1);
  assign ovf   = digit_overflow(KIND, raw, tens_at_two);
  assign carry = inc & ovf;
  assign value = DIGIT_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= ovf ? '0 : raw[STORE_W-1:0];
    end
  end

endmodule

// File: rtl/tod_bcd_counter.sv
module tod_bcd_counter
  import tod_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_tick,
  output logic [DIGIT_W-1:0] sec_ones,
  output logic [DIGIT_W-1:0] sec_tens,
  output logic [DIGIT_W-1:0] min_ones,
  output logic [DIGIT_W-1:0] min_tens,
  output logic [DIGIT_W-1:0] hr_ones,
  output logic [DIGIT_W-1:0] hr_tens,
  output logic               day_wrap
);

  localparam int LAST = NUM_DIGITS - 1;

  logic                 rst_active;
  logic                 hr_tens_two;
  logic [NUM_DIGITS-1:0] step_w;
  logic [NUM_DIGITS-1:0] carry_w;
  logic [DIGIT_W-1:0]   dig_w [NUM_DIGITS];
  logic                 wrap_q;

  tod_reset_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n_in   (rst_n),
    .rst_active (rst_active)
  );

  assign hr_tens_two = (dig_w[LAST] == DIGIT_W'(2));
  assign step_w      = {carry_w[NUM_DIGITS-2:0], sec_tick};

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    tod_digit #(.KIND(kind_of(g))) u_digit (
      .clk         (clk),
      .srst        (rst_active),
      .inc         (step_w[g]),
      .tens_at_two (hr_tens_two),
      .value       (dig_w[g]),
      .carry       (carry_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst_active) wrap_q <= 1'b0;
    else            wrap_q <= carry_w[LAST];
  end

  assign sec_ones = dig_w[0];
  assign sec_tens = dig_w[1];
  assign min_ones = dig_w[2];
  assign min_tens = dig_w[3];
  assign hr_ones  = dig_w[4];
  assign hr_tens  = dig_w[5];
  assign day_wrap = wrap_q;

endmodule

// File: rtl/tod_bcd_counter_chk.sv
module tod_bcd_counter_chk (
  input logic       clk,
  input logic       rst_active,
  input logic       tick,
  input logic [3:0] su,
  input logic [3:0] st,
  input logic [3:0] mu,
  input logic [3:0] mt,
  input logic [3:0] hu,
  input logic [3:0] ht,
  input logic       wrap
);

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst_active === 1'b1) armed <= 1'b1;
  end

  logic [23:0] time_w;
  assign time_w = {ht, hu, mt, mu, st, su};

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!armed || rst_active)
    $past(rst_active) |-> (time_w == 24'h0 && !wrap));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!armed || rst_active)
    !tick |=> $stable(time_w));

  assert_sec_units_range_R3: assert property (@(posedge clk) disable iff (!armed || rst_active)
    su <= 4'd9);

  assert_sec_units_step_R3: assert property (@(posedge clk) disable iff (!armed || rst_active)
    (tick && su != 4'd9) |=> su == $past(su) + 4'd1);

  assert_tens_range_R4: assert property (@(posedge clk) disable iff (!armed || rst_active)
    st <= 4'd5 && mt <= 4'd5);

  assert_min_carry_R5: assert property (@(posedge clk) disable iff (!armed || rst_active)
    (tick && su == 4'd9 && st == 4'd5 && mu != 4'd9) |=> mu == $past(mu) + 4'd1);

  assert_hr_units_range_R6: assert property (@(posedge clk) disable iff (!armed || rst_active)
    hu <= 4'd9);

  assert_hr_units_short_R7: assert property (@(posedge clk) disable iff (!armed || rst_active)
    ht == 4'd2 |-> hu <= 4'd3);

  assert_hr_tens_range_R8: assert property (@(posedge clk) disable iff (!armed || rst_active)
    ht <= 4'd2);

  assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!armed || rst_active)
    wrap |-> time_w == 24'h0);

  assert_wrap_single_R9: assert property (@(posedge clk) disable iff (!armed || rst_active)
    wrap |=> !wrap);

endmodule

bind tod_bcd_counter tod_bcd_counter_chk chk_i (
  .clk        (clk),
  .rst_active (rst_active),
  .tick       (sec_tick),
  .su         (sec_ones),
  .st         (sec_tens),
  .mu         (min_ones),
  .mt         (min_tens),
  .hu         (hr_ones),
  .ht         (hr_tens),
  .wrap       (day_wrap)
);

// File: tb/tod_bcd_counter_tb_top.sv
module tod_bcd_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;
  logic       day_wrap;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  bit cmp_on  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tod_bcd_counter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .sec_ones (sec_ones),
    .sec_tens (sec_tens),
    .min_ones (min_ones),
    .min_tens (min_tens),
    .hr_ones  (hr_ones),
    .hr_tens  (hr_tens),
    .day_wrap (day_wrap)
  );

  // Reference: seconds since midnight plus a two-cycle reset delay line.
  bit rst_seen [$] = '{1'b0, 1'b0};
  int ref_secs = 0;
  bit ref_wrap = 1'b0;

  always @(posedge clk) begin
    bit in_reset;
    in_reset = !rst_seen[0];
    void'(rst_seen.pop_front());
    rst_seen.push_back(rst_n);
    if (in_reset) begin
      ref_secs = 0;
      ref_wrap = 1'b0;
    end else if (sec_tick) begin
      ref_wrap = (ref_secs == 86399);
      ref_secs = (ref_secs + 1) % 86400;
    end else begin
      ref_wrap = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (cmp_on) begin
      int h, m, s;
      h = ref_secs / 3600;
      m = (ref_secs / 60) % 60;
      s = ref_secs % 60;
      check("R3 sec_ones", sec_ones, s % 10);
      check("R4 sec_tens", sec_tens, s / 10);
      check("R5 min_ones", min_ones, m % 10);
      check("R4 min_tens", min_tens, m / 10);
      check("R6 hr_ones",  hr_ones,  h % 10);
      check("R8 hr_tens",  hr_tens,  h / 10);
      check("R9 day_wrap", day_wrap, ref_wrap);
    end
  end

  function automatic int shown_secs();
    return (hr_tens * 10 + hr_ones) * 3600 + (min_tens * 10 + min_ones) * 60
           + sec_tens * 10 + sec_ones;
  endfunction

  function automatic bit any_hex();
    return sec_ones > 9 || sec_tens > 9 || min_ones > 9 || min_tens > 9
           || hr_ones > 9 || hr_tens > 9;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int lfsr = 32'h1ACE;
    int held;

    // R1: reset from power-up, ticking all the while
    sec_tick = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset clears time", shown_secs(), 0);
    check("R1 reset clears day_wrap", day_wrap, 0);
    cmp_on = 1'b1;
    sec_tick = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 still zero after release", shown_secs(), 0);

    // R10: first tick gives 00:00:01
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check("R10 first tick sec_ones", sec_ones, 1);
    check("R10 first tick time", shown_secs(), 1);

    // R2: no tick, nothing moves
    held = shown_secs();
    repeat (10) @(negedge clk);
    check("R2 hold without tick", shown_secs(), held);

    // Irregular tick spacing
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      sec_tick = lfsr[0] & lfsr[4];
      @(negedge clk);
      if (any_hex()) check("R10 no hex digit", 1, 0);
    end
    check("R3 sparse ticks advanced", shown_secs() > 300, 1);

    // R1: mid-run reset with ticks present
    sec_tick = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 mid-run reset", shown_secs(), 0);
    rst_n = 1'b1;
    sec_tick = 1'b0;
    repeat (3) @(negedge clk);

    // Full day of back-to-back ticks
    sec_tick = 1'b1;
    for (int i = 1; i < 86400; i++) begin
      @(negedge clk);
      if (any_hex()) check("R10 no hex digit", 1, 0);
      if (i == 36000) check("R6 10:00:00 reached", shown_secs(), 36000);
      if (i == 72000) check("R6 20:00:00 reached", hr_tens * 10 + hr_ones, 20);
    end
    check("R7 reaches 23:59:59", shown_secs(), 86399);
    check("R8 hr_tens at 2", hr_tens, 2);
    check("R9 no wrap before rollover", day_wrap, 0);
    @(negedge clk);
    sec_tick = 1'b0;
    check("R7 rolls to 00:00:00", shown_secs(), 0);
    check("R9 day_wrap pulse", day_wrap, 1);
    @(negedge clk);
    check("R9 day_wrap one cycle", day_wrap, 0);
    check("R2 idle after rollover", shown_secs(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule